// File: doc/BRIEF.md
# Address-Transition Standby Memory Controller

This block sits between a bus master and a synchronous single-port memory macro. The macro stays in a low-power standby state except for short bursts of activity. The block compares the incoming select, address and direction against their values on the previous cycle. When one of them changes while the block is selected, it wakes the macro for a fixed window of clocks, reads or writes the word, and then returns the macro to standby.

Read data is captured into an output latch on the last cycle of the window. The bus keeps seeing that latched word while the array sleeps, until a later read replaces it. The master needs no strobe or enable beyond its ordinary select, address and direction lines. A transition that arrives in the middle of a window restarts the window with the new request. Writes use the same window and leave the output latch as it was.

Top module: `atd_mem_wrap`

## Requirements
- R1: While reset is asserted and right after it is released, `standby` is 1, `memEn` is 0, `memWe` is 0 and `busRdata` is 0.
- R2: Whenever no access window is in progress, `standby` is 1 and `memEn` and `memWe` are 0. During a window, `standby` is 0 and `memEn` is 1.
- R3: A transition is a cycle in which `busSel` is 1 and at least one of these holds: `busSel` was 0 on the previous cycle, `busAddr` differs from its previous value, or `busWe` differs from its previous value. The clock edge that ends a transition cycle starts a window of exactly ACT_CYC cycles (default 2). During the window `memAddr` holds the address captured at that edge.
- R4: With `busSel` held at 1 and address and direction unchanged, no window starts. With `busSel` at 0, no window starts whatever the address does. In both cases `busRdata` keeps its value.
- R5: After a read window ends, `busRdata` equals the memory word at the captured address. During the window it keeps its previous value, and it then holds the new word until a later read window ends.
- R6: A transition during a window restarts the window, counted in full, with the new request. The word at the earlier address is never latched.
- R7: A write window drives `memWe` to 1 for the whole window, with the captured `busAddr` on `memAddr` and the captured `busWdata` on `memWdata`. `busRdata` does not change because of a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| busSel | input | 1 | Block select from the bus |
| busWe | input | 1 | 1 = write, 0 = read |
| busAddr | input | ADDR_W | Word address |
| busWdata | input | DATA_W | Write data |
| busRdata | output | DATA_W | Latched read data |
| standby | output | 1 | 1 while the array is idle |
| memEn | output | 1 | Memory macro enable |
| memWe | output | 1 | Memory macro write enable |
| memAddr | output | ADDR_W | Memory macro address |
| memWdata | output | DATA_W | Memory macro write data |
| memRdata | input | DATA_W | Memory macro read data, registered one clock after an enabled read |

## Verification
The bench goes after the corner cases most likely to break this block:

- **Address change in the middle of a window.** A design that fails to restart would latch the stale word or end the window early.
- **A read directly after a write to the same address, with select held high.** Only the direction changes. A detector blind to that change would never wake the array and would leave old data on the bus.
- **Select toggling and held-stable inputs.** A detector that is too eager would wake the array when the select drops or when idle addresses move. One that is too lax would miss a fresh select at an unchanged address.
- **Writes.** A write that leaked into the latch would alter `busRdata`.

Random read and write traffic is checked against a shadow copy of the memory.

// File: rtl/atd_pkg.sv
package atd_pkg;
  // Strobes passed from the control FSM to the datapath.
  typedef struct packed {
    logic load;     // capture request registers (transition edge)
    logic active;   // access window in progress
    logic capture;  // load output latch from memory read data
  } atdStrobe_t;
endpackage

// File: rtl/atd_ctrl.sv
module atd_ctrl
  import atd_pkg::*;
#(
  parameter int ACT_CYC = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       trans,
  input  logic       accWe,
  output atdStrobe_t strb
);
  localparam int CNT_W = (ACT_CYC > 1) ? $clog2(ACT_CYC) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(ACT_CYC - 1);

  logic             active;
  logic [CNT_W-1:0] cnt;
  logic             lastCyc;

  assign lastCyc = active && (cnt == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active <= 1'b0;
      cnt    <= '0;
    end else if (trans) begin
      active <= 1'b1;
      cnt    <= '0;
    end else if (active) begin
      if (cnt == LAST) begin
        active <= 1'b0;
        cnt    <= '0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  always_comb begin
    strb.load    = trans;
    strb.active  = active;
    strb.capture = lastCyc && !accWe && !trans;
  end

  // R3: a transition always opens a fresh window
  p_wake_on_change_r3: assert property (@(posedge clk) disable iff (!rst_n)
    trans |=> (active && cnt == '0));

  // R3: the window closes after its last cycle unless restarted
  p_sleep_after_window_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (lastCyc && !trans) |=> !active);

  // R4: no transition while idle keeps the array asleep
  p_quiet_no_change_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!active && !trans) |=> !active);

  initial begin
    p_act_cyc_min_r5: assert (ACT_CYC >= 2);
  end
endmodule

// File: rtl/atd_datapath.sv
module atd_datapath
  import atd_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              busSel,
  input  logic              busWe,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  input  logic [DATA_W-1:0] memRdata,
  input  atdStrobe_t        strb,
  output logic              trans,
  output logic              accWe,
  output logic [DATA_W-1:0] busRdata,
  output logic              memEn,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWdata
);
  logic              prevSel;
  logic              prevWe;
  logic [ADDR_W-1:0] prevAddr;
  logic [ADDR_W-1:0] accAddr;
  logic [DATA_W-1:0] accWdata;
  logic [DATA_W-1:0] rdataQ;

  // Transition detector: compare against last cycle's bus values
  assign trans = busSel && (!prevSel || (busAddr != prevAddr) || (busWe != prevWe));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prevSel  <= 1'b0;
      prevWe   <= 1'b0;
      prevAddr <= '0;
    end else begin
      prevSel  <= busSel;
      prevWe   <= busWe;
      prevAddr <= busAddr;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      accAddr  <= '0;
      accWdata <= '0;
      accWe    <= 1'b0;
    end else if (strb.load) begin
      accAddr  <= busAddr;
      accWdata <= busWdata;
      accWe    <= busWe;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)            rdataQ <= '0;
    else if (strb.capture) rdataQ <= memRdata;
  end

  assign busRdata = rdataQ;
  assign memEn    = strb.active;
  assign memWe    = strb.active && accWe;
  assign memAddr  = accAddr;
  assign memWdata = accWdata;

  // R5: the output latch only moves on a capture strobe
  p_hold_latch_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !strb.capture |=> $stable(rdataQ));

  // R6: without a new transition the captured request stays put
  p_request_stable_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !trans |=> ($stable(accAddr) && $stable(accWe)));

  // R7: a write window never loads the output latch
  p_write_no_latch_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (strb.active && accWe && !trans) |=> $stable(rdataQ));
endmodule

// File: rtl/atd_mem_wrap.sv
module atd_mem_wrap
  import atd_pkg::*;
#(
  parameter int ADDR_W  = 6,
  parameter int DATA_W  = 16,
  parameter int ACT_CYC = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              busSel,
  input  logic              busWe,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  output logic              standby,
  output logic              memEn,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWdata,
  input  logic [DATA_W-1:0] memRdata
);
  atdStrobe_t strb;
  logic       trans;
  logic       accWe;

  atd_ctrl #(.ACT_CYC(ACT_CYC)) u_ctrl (
    .clk   (clk),
    .rst_n (rst_n),
    .trans (trans),
    .accWe (accWe),
    .strb  (strb)
  );

  atd_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
    .clk      (clk),
    .rst_n    (rst_n),
    .busSel   (busSel),
    .busWe    (busWe),
    .busAddr  (busAddr),
    .busWdata (busWdata),
    .memRdata (memRdata),
    .strb     (strb),
    .trans    (trans),
    .accWe    (accWe),
    .busRdata (busRdata),
    .memEn    (memEn),
    .memWe    (memWe),
    .memAddr  (memAddr),
    .memWdata (memWdata)
  );

  assign standby = !strb.active;

  // R2: a write strobe never appears outside an active window
  p_we_in_window_r2: assert property (@(posedge clk) disable iff (!rst_n)
    memWe |-> memEn);
endmodule

// File: tb/atd_mem_wrap_test.sv
`timescale 1ns/1ps
module atd_mem_wrap_test;
  localparam int ADDR_W  = 6;
  localparam int DATA_W  = 16;
  localparam int ACT_CYC = 2;
  localparam int DEPTH   = 1 << ADDR_W;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              busSel, busWe;
  logic [ADDR_W-1:0] busAddr;
  logic [DATA_W-1:0] busWdata;
  logic [DATA_W-1:0] busRdata;
  logic              standby, memEn, memWe;
  logic [ADDR_W-1:0] memAddr;
  logic [DATA_W-1:0] memWdata;
  logic [DATA_W-1:0] memRdata;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  logic [DATA_W-1:0] memArr [DEPTH];
  logic [DATA_W-1:0] expArr [DEPTH];
  logic [DATA_W-1:0] expLatch;

  always #2 clk = ~clk;

  atd_mem_wrap #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .ACT_CYC(ACT_CYC)) uut (
    .clk(clk), .rst_n(rst_n), .busSel(busSel), .busWe(busWe),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
    .standby(standby), .memEn(memEn), .memWe(memWe), .memAddr(memAddr),
    .memWdata(memWdata), .memRdata(memRdata)
  );

  function automatic logic [DATA_W-1:0] initWord(int i);
    return DATA_W'(i * 16'h1357) ^ 16'hA5C3;
  endfunction

  // Behavioural synchronous memory macro
  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) memArr[i] <= initWord(i);
      memRdata <= '0;
    end else if (memEn) begin
      if (memWe) memArr[memAddr] <= memWdata;
      else       memRdata <= memArr[memAddr];
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic idleDeselect();
    @(negedge clk);
    busSel = 1'b0;
    @(posedge clk);
    @(negedge clk);
    chk(standby == 1'b1, "R4 deselect wakes nothing", 32'(standby), 32'd1);
  endtask

  // Issue a request at a negedge (it must form a transition) and follow its window.
  task automatic runAccess(input logic we, input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] wd);
    @(negedge clk);
    busSel = 1'b1; busWe = we; busAddr = a; busWdata = wd;
    @(posedge clk);
    @(negedge clk);
    chk(standby == 1'b0 && memEn == 1'b1, "R2 window active", 32'(standby), 32'd0);
    chk(memAddr == a, "R3 captured address", 32'(memAddr), 32'(a));
    if (we) begin
      chk(memWe == 1'b1 && memWdata == wd, "R7 write strobe and data", 32'(memWdata), 32'(wd));
    end else begin
      chk(memWe == 1'b0, "R7 no write on read", 32'(memWe), 32'd0);
    end
    for (int k = 1; k < ACT_CYC; k++) begin
      @(posedge clk);
      @(negedge clk);
      chk(standby == 1'b0, "R3 window length", 32'(standby), 32'd0);
    end
    chk(busRdata == expLatch, "R5 latch held during window", 32'(busRdata), 32'(expLatch));
    @(posedge clk);
    @(negedge clk);
    chk(standby == 1'b1 && memEn == 1'b0, "R3 back to standby", 32'(standby), 32'd1);
    if (we) begin
      expArr[a] = wd;
      chk(busRdata == expLatch, "R7 write leaves latch", 32'(busRdata), 32'(expLatch));
    end else begin
      expLatch = expArr[a];
      chk(busRdata == expLatch, "R5 read data latched", 32'(busRdata), 32'(expLatch));
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [ADDR_W-1:0] a;
    logic [ADDR_W-1:0] b;
    int unsigned seed;
    seed = $urandom(32'd4242);
    for (int i = 0; i < DEPTH; i++) expArr[i] = initWord(i);
    expLatch = '0;
    rst_n = 1'b0; busSel = 1'b0; busWe = 1'b0; busAddr = '0; busWdata = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    chk(standby == 1'b1 && memEn == 1'b0 && memWe == 1'b0, "R1 reset control", 32'(memEn), 32'd0);
    chk(busRdata == '0, "R1 reset data", 32'(busRdata), 32'd0);
    rst_n = 1'b1;
    @(posedge clk);
    @(negedge clk);
    chk(standby == 1'b1 && busRdata == '0, "R1 after release", 32'(busRdata), 32'd0);

    // Directed reads
    runAccess(1'b0, 6'd5, '0);
    runAccess(1'b0, 6'd63, '0);
    // R4: hold the same request, nothing wakes
    for (int k = 0; k < 5; k++) begin
      @(posedge clk);
      @(negedge clk);
      chk(standby == 1'b1 && busRdata == expLatch, "R4 stable inputs stay asleep", 32'(standby), 32'd1);
    end
    // R4: address moves while deselected
    @(negedge clk);
    busSel = 1'b0;
    for (int k = 0; k < 5; k++) begin
      busAddr = ADDR_W'(k * 7 + 3);
      @(posedge clk);
      @(negedge clk);
      chk(standby == 1'b1 && busRdata == expLatch, "R4 deselected address change", 32'(standby), 32'd1);
    end
    // Reselect at the same address is a transition
    runAccess(1'b0, busAddr, '0);

    // R7: write then read back, direction change alone triggers
    idleDeselect();
    runAccess(1'b1, 6'd9, 16'hBEEF);
    runAccess(1'b0, 6'd9, '0);
    chk(busRdata == 16'hBEEF, "R7 written word read back", 32'(busRdata), 32'hBEEF);

    // R6: restart mid-window
    idleDeselect();
    a = 6'd12; b = 6'd40;
    @(negedge clk);
    busSel = 1'b1; busWe = 1'b0; busAddr = a;
    @(posedge clk);
    @(negedge clk);
    busAddr = b;
    @(posedge clk);
    @(negedge clk);
    chk(standby == 1'b0 && memAddr == b, "R6 restart captures new address", 32'(memAddr), 32'(b));
    for (int k = 1; k < ACT_CYC; k++) begin
      @(posedge clk);
      @(negedge clk);
      chk(standby == 1'b0 && busRdata == expLatch, "R6 restarted window full length", 32'(busRdata), 32'(expLatch));
    end
    @(posedge clk);
    @(negedge clk);
    expLatch = expArr[b];
    chk(standby == 1'b1 && busRdata == expLatch, "R6 new address latched", 32'(busRdata), 32'(expLatch));

    // Random traffic
    for (int n = 0; n < 300; n++) begin
      logic w;
      w = ($urandom % 3) == 0;
      a = ADDR_W'($urandom);
      idleDeselect();
      runAccess(w, a, DATA_W'($urandom));
      if (($urandom % 4) == 0) begin
        @(posedge clk);
        @(negedge clk);
        chk(standby == 1'b1 && busRdata == expLatch, "R4 idle hold", 32'(busRdata), 32'(expLatch));
      end
    end

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule